// File: doc/BRIEF.md
# Context-State Table Builder for an Arithmetic-Coded Video Entropy Stage

This block fills a memory with the starting probability state of every context used by an arithmetic-coded video entropy coder, for every quantiser value from 0 to 51. A table memory outside the block supplies one signed slope/offset pair per context. The builder combines that pair with the quantiser value, clips the result, and turns it into one byte that holds the state number and the most-probable-symbol bit. Each group of eight bytes leaves the block as one 64-bit write, already in the byte order that a big-endian reader of 32-bit words expects.

Two model sets exist for each quantiser. Set 0 is the intra set. Set 1 is one of three inter sets, chosen by the selector given with the request. The table is rebuilt only when the selector changes to a valid value. A negative selector means the entropy mode does not use these tables: it produces no writes, but the block still records it as the most recent selector.

Top module: `cabac_ctx_table_gen`

## Requirements
- R1: After reset, and until a request is accepted, `wr_en` and `done` stay low.
- R2: A `start` pulse with `req_idc` in 0..2 that differs from the most recently accepted selector starts a full build. The remembered selector is -1 out of reset.
- R3: For quantiser q and pair (m, n), read as signed bytes with m in bits 15:8, the state is p = ((m*q) arithmetically shifted right by 4) + n, clipped to the range 1..126.
- R4: A state p <= 63 encodes as (63-p)<<1, with the low bit 0. A state p >= 64 encodes as ((p-64)<<1)|1. No encoded byte exceeds 125.
- R5: The pair for context c is read at address c for set 0, and at address 460*(1+idc)+c for set 1. Read data is used one cycle after `tbl_rd_en`. Padding contexts are never read, so a build makes exactly 47840 reads.
- R6: Byte address q*928 + s*464 + c holds the byte for quantiser q, set s and context c (c < 460). Contexts 460..463 of each set hold 0.
- R7: Word address w carries bytes 8w..8w+7, with byte 8w+k in bits [63-8k:56-8k]. Words 0..6031 are each written once, in rising order, and never in two consecutive cycles.
- R8: `done` pulses for one cycle, in the cycle after the write of word 6031.
- R9: A `start` whose selector is negative, is 3, or equals the most recently accepted selector produces no reads and no writes. It pulses `done` in the following cycle and becomes the remembered selector.
- R10: A `start` that arrives while a build is in progress, or while its pipeline is still draining, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| req_idc | input | 3 | Signed inter-set selector; negative means the tables are not needed |
| tbl_rd_en | output | 1 | Read strobe to the slope/offset table |
| tbl_addr | output | 11 | Table read address |
| tbl_rdata | input | 16 | {m, n}, valid one cycle after the strobe |
| wr_en | output | 1 | Output word write strobe |
| wr_addr | output | 13 | Output word address |
| wr_data | output | 64 | Output word, already reordered |
| done | output | 1 | Request finished pulse |

## Verification
The assertions assume that the table memory returns its data exactly one cycle after the strobe, and that `req_idc` is a 3-bit signed value. Any stored pair is then legal, because clipping bounds every byte. The bench models the table as a registered memory. It fills the memory with seeded random pairs, and plants directed entries that drive the state to both clip limits, to the 63/64 boundary, and to a negative product that rounds toward minus infinity. Requests are only sent as single-cycle pulses. Selector values cover the valid, negative, out-of-range and repeated cases, plus one request sent during a build.

// File: rtl/cabac_gen_pkg.sv
package cabac_gen_pkg;
    localparam int QP_NUM     = 52;
    localparam int CTX_NUM    = 460;
    localparam int CTX_STRIDE = 464;
    localparam int SET_NUM    = 2;
    localparam int INTER_SETS = 3;
    localparam int COEF_W     = 8;
    localparam int STATE_MIN  = 1;
    localparam int STATE_MAX  = 126;
    localparam int STATE_MID  = 63;

    localparam int TBL_DEPTH  = CTX_NUM * (1 + INTER_SETS);
    localparam int TBL_AW     = $clog2(TBL_DEPTH);
    localparam int BYTES      = QP_NUM * SET_NUM * CTX_STRIDE;
    localparam int WORDS      = BYTES / 8;
    localparam int WAW        = $clog2(WORDS);
    localparam int QP_W       = $clog2(QP_NUM);
    localparam int CTX_W      = $clog2(CTX_STRIDE);
    localparam int MAX_BYTE   = ((STATE_MAX - STATE_MID - 1) << 1) | 1;
    localparam int PROD_W     = 2 * COEF_W;

    typedef struct packed {
        logic [QP_W-1:0]  qp;
        logic             set;
        logic [CTX_W-1:0] ctx;
    } pos_t;

    typedef struct packed {
        logic valid;
        logic last;
        logic pad;
        pos_t pos;
    } issue_t;

    function automatic logic [7:0] state_byte(input logic signed [COEF_W-1:0] m,
                                              input logic signed [COEF_W-1:0] n,
                                              input logic [QP_W-1:0] qp);
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] pre;
        prod = PROD_W'(m) * PROD_W'($signed({1'b0, qp}));
        pre  = (prod >>> 4) + PROD_W'(n);
        if (pre < PROD_W'(STATE_MIN))      pre = PROD_W'(STATE_MIN);
        else if (pre > PROD_W'(STATE_MAX)) pre = PROD_W'(STATE_MAX);
        if (pre <= PROD_W'(STATE_MID))
            return 8'((PROD_W'(STATE_MID) - pre) <<< 1);
        else
            return 8'(((pre - PROD_W'(STATE_MID + 1)) <<< 1) | PROD_W'(1));
    endfunction
endpackage

// File: rtl/cabac_seq.sv
module cabac_seq
    import cabac_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic signed [2:0] req_idc,
    input  logic              pipe_busy,
    output issue_t            iss,
    output logic [TBL_AW-1:0] tbl_addr,
    output logic              tbl_rd_en,
    output logic              skip_done
);
    logic              running;
    pos_t              pos;
    logic [1:0]        gen_idc;
    logic signed [2:0] last_idc;
    logic              accept, valid_idc, go, at_end;
    logic [TBL_AW-1:0] base;

    assign accept    = start && !running && !pipe_busy;
    assign valid_idc = (req_idc >= 3'sd0) && (req_idc <= 3'sd2);
    assign go        = accept && valid_idc && (req_idc != last_idc);
    assign at_end    = (pos.qp == QP_W'(QP_NUM - 1)) && pos.set
                       && (pos.ctx == CTX_W'(CTX_STRIDE - 1));

    always_comb begin
        iss.valid = running;
        iss.last  = running && at_end;
        iss.pad   = pos.ctx >= CTX_W'(CTX_NUM);
        iss.pos   = pos;
        base      = pos.set ? TBL_AW'(CTX_NUM) * (TBL_AW'(gen_idc) + TBL_AW'(1)) : '0;
        tbl_addr  = base + TBL_AW'(pos.ctx);
        tbl_rd_en = running && !iss.pad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            pos       <= '0;
            gen_idc   <= '0;
            last_idc  <= -3'sd1;
            skip_done <= 1'b0;
        end else begin
            skip_done <= accept && !go;
            if (accept) last_idc <= req_idc;
            if (go) begin
                running <= 1'b1;
                pos     <= '0;
                gen_idc <= req_idc[1:0];
            end else if (running) begin
                if (pos.ctx == CTX_W'(CTX_STRIDE - 1)) begin
                    pos.ctx <= '0;
                    pos.set <= ~pos.set;
                    if (pos.set) begin
                        if (pos.qp == QP_W'(QP_NUM - 1)) running <= 1'b0;
                        else pos.qp <= pos.qp + 1'b1;
                    end
                end else begin
                    pos.ctx <= pos.ctx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cabac_pack.sv
module cabac_pack
    import cabac_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  issue_t              iss,
    input  logic [2*COEF_W-1:0] tbl_rdata,
    output logic                pipe_busy,
    output logic                wr_en,
    output logic [WAW-1:0]      wr_addr,
    output logic [63:0]         wr_data,
    output logic                fin
);
    issue_t         s1;
    logic [63:0]    pack, pack_next;
    logic [7:0]     byte_val;
    logic [2:0]     lane;
    logic           lane_full;
    logic           wr_last;
    logic [WAW-1:0] word_cnt;

    assign lane      = s1.pos.ctx[2:0];
    assign lane_full = s1.valid && (lane == 3'd7);
    assign pipe_busy = s1.valid || wr_en;

    always_comb begin
        byte_val  = s1.pad ? 8'h00
                  : state_byte(tbl_rdata[2*COEF_W-1:COEF_W], tbl_rdata[COEF_W-1:0], s1.pos.qp);
        pack_next = pack;
        pack_next[{3'd7 - lane, 3'b000} +: 8] = byte_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= '0;
            pack     <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_last  <= 1'b0;
            word_cnt <= '0;
            fin      <= 1'b0;
        end else begin
            s1    <= iss;
            wr_en <= lane_full;
            fin   <= wr_en && wr_last;
            if (s1.valid) pack <= pack_next;
            if (lane_full) begin
                wr_data  <= pack_next;
                wr_addr  <= word_cnt;
                wr_last  <= s1.last;
                word_cnt <= s1.last ? '0 : word_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cabac_ctx_table_gen.sv
module cabac_ctx_table_gen
    import cabac_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic signed [2:0]   req_idc,
    output logic                tbl_rd_en,
    output logic [TBL_AW-1:0]   tbl_addr,
    input  logic [2*COEF_W-1:0] tbl_rdata,
    output logic                wr_en,
    output logic [WAW-1:0]      wr_addr,
    output logic [63:0]         wr_data,
    output logic                done
);
    issue_t iss;
    logic   pipe_busy, skip_done, fin;

    cabac_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .req_idc(req_idc),
        .pipe_busy(pipe_busy), .iss(iss), .tbl_addr(tbl_addr),
        .tbl_rd_en(tbl_rd_en), .skip_done(skip_done)
    );

    cabac_pack u_pack (
        .clk(clk), .rst(rst), .iss(iss), .tbl_rdata(tbl_rdata),
        .pipe_busy(pipe_busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fin(fin)
    );

    assign done = skip_done || fin;
endmodule

// File: rtl/cabac_ctx_table_gen_chk.sv
module cabac_ctx_table_gen_chk
    import cabac_gen_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                tbl_rd_en,
    input logic [TBL_AW-1:0]   tbl_addr,
    input logic                wr_en,
    input logic [WAW-1:0]      wr_addr,
    input logic [63:0]         wr_data,
    input logic                done
);
    logic [WAW-1:0] next_word;
    logic           bytes_ok;

    always_comb begin
        bytes_ok = 1'b1;
        for (int k = 0; k < 8; k++)
            if (wr_data[8*k +: 8] > 8'(MAX_BYTE)) bytes_ok = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) next_word <= '0;
        else if (wr_en) next_word <= (wr_addr == WAW'(WORDS - 1)) ? '0 : wr_addr + 1'b1;
    end

    a_r4_byte_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> bytes_ok);
    a_r5_addr_range: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_en |-> (tbl_addr < TBL_AW'(TBL_DEPTH)));
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    a_r7_addr_order: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr == next_word));
    a_r8_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> (($past(wr_en) && ($past(wr_addr) == WAW'(WORDS - 1))) || $past(start)));
    a_r1_quiet_with_no_request: assert property (@(posedge clk) disable iff (rst)
        (wr_en || done) |-> !$stable(next_word) || wr_en || $past(start) || $past(wr_en));
endmodule

bind cabac_ctx_table_gen cabac_ctx_table_gen_chk chk_i (
    .clk(clk), .rst(rst), .start(start), .tbl_rd_en(tbl_rd_en),
    .tbl_addr(tbl_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
);

// File: tb/cabac_ctx_table_gen_tb_top.sv
module cabac_ctx_table_gen_tb_top;
    import cabac_gen_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic signed [2:0] req_idc = 3'sd0;
    logic              tbl_rd_en;
    logic [TBL_AW-1:0] tbl_addr;
    logic [15:0]       tbl_rdata = '0;
    logic              wr_en, done;
    logic [WAW-1:0]    wr_addr;
    logic [63:0]       wr_data;

    logic [15:0] tbl_mem [TBL_DEPTH];
    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, cyc = 0;
    int last_wr_cyc = -10, last_done_cyc = -1;
    int gen_idc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cabac_ctx_table_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .req_idc(req_idc),
        .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    always @(posedge clk) if (tbl_rd_en) tbl_rdata <= tbl_mem[tbl_addr];

    function automatic int exp_byte(int qp, int set, int ctx, int idc);
        int a, m, n, pre;
        if (ctx >= 460) return 0;
        a   = set ? 460 * (1 + idc) + ctx : ctx;
        m   = int'($signed(tbl_mem[a][15:8]));
        n   = int'($signed(tbl_mem[a][7:0]));
        pre = ((m * qp) >>> 4) + n;
        if (pre < 1) pre = 1;
        if (pre > 126) pre = 126;
        return (pre <= 63) ? ((63 - pre) * 2) : ((pre - 64) * 2 + 1);
    endfunction

    function automatic logic [63:0] exp_word(int w, int idc);
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            int b = 8 * w + k;
            r[63 - 8 * k -: 8] = 8'(exp_byte(b / 928, (b % 928) / 464, b % 464, idc));
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (tbl_rd_en) rd_cnt++;
            if (done) begin
                done_cnt++;
                last_done_cyc = cyc;
            end
            if (wr_en) begin
                // R3 R4 R6 R7: word content and ordering
                check(wr_data == exp_word(int'(wr_addr), gen_idc), "R3/R4/R6/R7 word",
                      longint'(wr_data), longint'(exp_word(int'(wr_addr), gen_idc)));
                check(int'(wr_addr) == wr_cnt % WORDS, "R7 address order",
                      longint'(wr_addr), longint'(wr_cnt % WORDS));
                wr_cnt++;
                last_wr_cyc = cyc;
            end
        end
    end

    task automatic pulse(int idc);
        @(negedge clk);
        start   = 1'b1;
        req_idc = 3'(idc);
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic full_build(int idc, bit poke_mid);
        int d0 = done_cnt, w0 = wr_cnt, r0 = rd_cnt;
        gen_idc = idc;
        pulse(idc);
        if (poke_mid) begin
            repeat (100) @(negedge clk);
            pulse((idc + 2) % 3); // R10: request during build
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(wr_cnt - w0 == WORDS, "R2/R7 words per build", wr_cnt - w0, WORDS);
        check(rd_cnt - r0 == 47840, "R5 reads per build", rd_cnt - r0, 47840);
        check(done_cnt - d0 == 1, "R8/R10 single done", done_cnt - d0, 1);
        check(last_done_cyc == last_wr_cyc + 1, "R8 done timing",
              last_done_cyc, last_wr_cyc + 1);
    endtask

    task automatic skip_req(int idc);
        int d0 = done_cnt, w0 = wr_cnt, r0 = rd_cnt;
        pulse(idc);
        check(done == 1'b1, "R9 done next cycle", done, 1);
        repeat (3) @(negedge clk);
        check(done_cnt - d0 == 1, "R9 skip done count", done_cnt - d0, 1);
        check(wr_cnt == w0, "R9 no writes", wr_cnt - w0, 0);
        check(rd_cnt == r0, "R9 no reads", rd_cnt - r0, 0);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < TBL_DEPTH; i++) tbl_mem[i] = 16'($urandom());
        tbl_mem[0] = {8'sh80, 8'sh80};   // low clip
        tbl_mem[1] = {8'sh7f, 8'sh7f};   // high clip
        tbl_mem[2] = {8'sh00, 8'sd63};   // boundary 63
        tbl_mem[3] = {8'sh00, 8'sd64};   // boundary 64
        tbl_mem[4] = {8'shff, 8'sd10};   // negative product rounding
        for (int s = 0; s < 3; s++) begin
            tbl_mem[460 * (s + 1) + 0] = {8'sh80, 8'sh7f};
            tbl_mem[460 * (s + 1) + 1] = {8'shff, 8'sd10};
            tbl_mem[460 * (s + 1) + 459] = {8'sh7f, 8'sh80};
        end
        repeat (5) @(negedge clk);
        check(wr_en == 1'b0, "R1 reset wr_en", wr_en, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0, "R1 idle after reset", {wr_en, done}, 0);
        full_build(0, 1'b1);  // R2 R10
        skip_req(0);          // R9 repeated selector
        skip_req(-1);         // R9 negative selector
        full_build(0, 1'b0);  // R2 R9: regenerate after negative
        skip_req(3);          // R9 out of range
        full_build(2, 1'b0);  // R2 R5 other inter set
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hang expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule